// File: doc/BRIEF.md
# SCSI Controller CPU Register Interface

This block is the processor-facing register file and address decoder of a SCSI protocol controller. A host processor reaches it through a 3-bit address, an 8-bit data bus and active-low chip-select, read and write strobes. Each of the eight addresses can name one register for reads and a different register, or an action, for writes. The block stores the writable control registers. It returns live status from the SCSI side on reads. It converts accesses to the command addresses into one-clock action strobes.

The host strobes are asynchronous to the block clock, so they pass through a synchronizer before any register is updated or any strobe fires. The data bus is split into an input, an output and an output-enable, which a pad ring joins into the bidirectional bus. The SCSI line drivers and the DMA sequencer attach to the internal-side ports.

Top module: `scsi_cpu_regs`

## Requirements
- R1: A write takes effect only while cs_ni and wr_ni are both low. A read side effect happens only while cs_ni and rd_ni are both low. With cs_ni high, neither strobe changes any register or fires any action.
- R2: data_oe_o is 1 exactly while cs_ni and rd_ni are both low, and 0 otherwise, including during a write cycle.
- R3: Addresses 1, 2 and 3 are read/write registers, driven out on init_cmd_o, mode_o and targ_cmd_o; a read returns the last value written. A write to address 4 stores the select-enable value on sel_enable_o.
- R4: A write to address 0 stores out_data_o. A read of address 0 returns the live scsi_data_i.
- R5: Reads of addresses 4, 5 and 6 return bus_status_i, bus_and_status_i and input_data_i respectively. A read of address 7 returns 0x00.
- R6: Writes to addresses 5, 6 and 7 pulse dma_send_o, dma_targ_rx_o and dma_init_rx_o respectively. The written data is ignored and no stored register changes.
- R7: A read of address 7 pulses clr_flags_o. Reads of any other address fire no strobe.
- R8: Each access yields at most one strobe pulse, one clock wide, however long the host strobe is held. At most one action strobe is high in any cycle. The strobe is high in the clock following the third rising edge after the access begins, and a stored register updates on that same edge.
- R9: While rst_ni is low, all stored registers and all strobes are 0. The block has no output toward the SCSI bus reset line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Drive enable for host data bus |
| scsi_data_i | input | 8 | Live SCSI data bus value |
| bus_status_i | input | 8 | Current bus status |
| bus_and_status_i | input | 8 | Combined bus and status flags |
| input_data_i | input | 8 | Latched input data |
| out_data_o | output | 8 | Output data register |
| init_cmd_o | output | 8 | Initiator command register |
| mode_o | output | 8 | Mode register |
| targ_cmd_o | output | 8 | Target command register |
| sel_enable_o | output | 8 | Select enable register |
| dma_send_o | output | 1 | Start DMA send strobe |
| dma_targ_rx_o | output | 1 | Start DMA target receive strobe |
| dma_init_rx_o | output | 1 | Start DMA initiator receive strobe |
| clr_flags_o | output | 1 | Clear parity/interrupt strobe |

## Verification
Every address is written and then read back with a distinct data byte. Each internal-side source carries a distinct constant, so a read served by the wrong source shows up as a wrong value, and a stored register is told apart from a live one. After each access, a model of all stored registers and per-strobe pulse counts is compared against the outputs. This separates a wrong write decode, a lost write-only action and a wrong read side effect. Directed cases cover deselected strobes, long-held strobes, a drive-enable check during writes, and reset in the middle of operation.

// File: rtl/scsi_regs_pkg.sv
`timescale 1ns/1ps
package scsi_regs_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_ADDR = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DATA  = 3'd0,
    ADR_ICMD  = 3'd1,
    ADR_MODE  = 3'd2,
    ADR_TCMD  = 3'd3,
    ADR_STAT  = 3'd4,
    ADR_BSTAT = 3'd5,
    ADR_INDAT = 3'd6,
    ADR_CLR   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/scsi_sync.sv
`timescale 1ns/1ps
module scsi_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/scsi_edge_pulse.sv
`timescale 1ns/1ps
module scsi_edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else level_q <= level_i;
  end

  assign pulse_o = level_i & ~level_q;
endmodule

// File: rtl/scsi_reg_bank.sv
`timescale 1ns/1ps
module scsi_reg_bank
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_pulse_i,
  input  logic              rd_pulse_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] init_cmd_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] targ_cmd_o,
  output logic [DATA_W-1:0] sel_enable_o,
  output logic              dma_send_o,
  output logic              dma_targ_rx_o,
  output logic              dma_init_rx_o,
  output logic              clr_flags_o
);
  reg_addr_e adr;
  assign adr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o    <= '0;
      init_cmd_o    <= '0;
      mode_o        <= '0;
      targ_cmd_o    <= '0;
      sel_enable_o  <= '0;
      dma_send_o    <= 1'b0;
      dma_targ_rx_o <= 1'b0;
      dma_init_rx_o <= 1'b0;
      clr_flags_o   <= 1'b0;
    end else begin
      dma_send_o    <= 1'b0;
      dma_targ_rx_o <= 1'b0;
      dma_init_rx_o <= 1'b0;
      clr_flags_o   <= rd_pulse_i && (adr == ADR_CLR);
      if (wr_pulse_i) begin
        case (adr)
          ADR_DATA:  out_data_o    <= data_i;
          ADR_ICMD:  init_cmd_o    <= data_i;
          ADR_MODE:  mode_o        <= data_i;
          ADR_TCMD:  targ_cmd_o    <= data_i;
          ADR_STAT:  sel_enable_o  <= data_i;
          ADR_BSTAT: dma_send_o    <= 1'b1; // action only, data dropped
          ADR_INDAT: dma_targ_rx_o <= 1'b1;
          ADR_CLR:   dma_init_rx_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_read_mux.sv
`timescale 1ns/1ps
module scsi_read_mux
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] scsi_data_i,
  input  logic [DATA_W-1:0] init_cmd_i,
  input  logic [DATA_W-1:0] mode_i,
  input  logic [DATA_W-1:0] targ_cmd_i,
  input  logic [DATA_W-1:0] bus_status_i,
  input  logic [DATA_W-1:0] bus_and_status_i,
  input  logic [DATA_W-1:0] input_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    case (reg_addr_e'(addr_i))
      ADR_DATA:  sel_d = scsi_data_i;
      ADR_ICMD:  sel_d = init_cmd_i;
      ADR_MODE:  sel_d = mode_i;
      ADR_TCMD:  sel_d = targ_cmd_i;
      ADR_STAT:  sel_d = bus_status_i;
      ADR_BSTAT: sel_d = bus_and_status_i;
      ADR_INDAT: sel_d = input_data_i;
      default:   sel_d = '0;
    endcase
  end

  assign data_o = rd_en_i ? sel_d : '0;
endmodule

// File: rtl/scsi_cpu_regs.sv
`timescale 1ns/1ps
module scsi_cpu_regs
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] scsi_data_i,
  input  logic [DATA_W-1:0] bus_status_i,
  input  logic [DATA_W-1:0] bus_and_status_i,
  input  logic [DATA_W-1:0] input_data_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] init_cmd_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] targ_cmd_o,
  output logic [DATA_W-1:0] sel_enable_o,
  output logic              dma_send_o,
  output logic              dma_targ_rx_o,
  output logic              dma_init_rx_o,
  output logic              clr_flags_o
);
  logic [2:0] strb_s;
  logic       cs_s, rd_s, wr_s;
  logic       rd_pulse, wr_pulse;

  scsi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, rd_ni, wr_ni}),
    .q_o (strb_s)
  );
  assign {cs_s, rd_s, wr_s} = strb_s;

  scsi_edge_pulse u_rd_edge (
    .clk_i, .rst_ni, .level_i(~cs_s & ~rd_s), .pulse_o(rd_pulse)
  );
  scsi_edge_pulse u_wr_edge (
    .clk_i, .rst_ni, .level_i(~cs_s & ~wr_s), .pulse_o(wr_pulse)
  );

  // bus drive follows raw pins so read data appears without sync delay
  assign data_oe_o = ~cs_ni & ~rd_ni;

  scsi_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_pulse_i (wr_pulse),
    .rd_pulse_i (rd_pulse),
    .addr_i, .data_i,
    .out_data_o, .init_cmd_o, .mode_o, .targ_cmd_o, .sel_enable_o,
    .dma_send_o, .dma_targ_rx_o, .dma_init_rx_o, .clr_flags_o
  );

  scsi_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .addr_i,
    .rd_en_i          (data_oe_o),
    .scsi_data_i,
    .init_cmd_i       (init_cmd_o),
    .mode_i           (mode_o),
    .targ_cmd_i       (targ_cmd_o),
    .bus_status_i,
    .bus_and_status_i,
    .input_data_i,
    .data_o
  );
endmodule

// File: rtl/scsi_cpu_regs_chk.sv
`timescale 1ns/1ps
module scsi_cpu_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] init_cmd_o,
  input logic              dma_send_o,
  input logic              dma_targ_rx_o,
  input logic              dma_init_rx_o,
  input logic              clr_flags_o
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_send_o, dma_targ_rx_o, dma_init_rx_o, clr_flags_o})); // R8

  AST_SEND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_send_o |=> !dma_send_o); // R6

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |=> !clr_flags_o); // R7

  AST_WR_STROBE_NEEDS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_send_o || dma_targ_rx_o || dma_init_rx_o) |-> $past(!cs_ni && !wr_ni, 3)); // R1

  AST_CLR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |-> $past(!cs_ni && !rd_ni, 3)); // R7

  AST_MODE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(!cs_ni && !wr_ni, 3) |-> $stable(mode_o)); // R3

  AST_ICMD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(!cs_ni && !wr_ni, 3) |-> $stable(init_cmd_o)); // R3
endmodule

bind scsi_cpu_regs scsi_cpu_regs_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .mode_o, .init_cmd_o,
  .dma_send_o, .dma_targ_rx_o, .dma_init_rx_o, .clr_flags_o
);

// File: tb/scsi_cpu_regs_tb.sv
`timescale 1ns/1ps
module scsi_cpu_regs_tb_top;
  localparam logic [7:0] SCSI_V = 8'h81;
  localparam logic [7:0] STAT_V = 8'h42;
  localparam logic [7:0] BST_V  = 8'h24;
  localparam logic [7:0] IND_V  = 8'hE7;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp_rd;
    logic [3:0] exp_strb; // {clr, init_rx, targ_rx, send}
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd1, 8'hA5, 8'hA5, 4'h0},
    '{3'd2, 8'h3C, 8'h3C, 4'h0},
    '{3'd3, 8'h0F, 8'h0F, 4'h0},
    '{3'd1, 8'h5A, 8'h5A, 4'h0},
    '{3'd0, 8'h77, SCSI_V, 4'h0},
    '{3'd4, 8'hC3, STAT_V, 4'h0},
    '{3'd5, 8'h99, BST_V, 4'h1},
    '{3'd6, 8'h11, IND_V, 4'h2},
    '{3'd7, 8'h22, 8'h00, 4'hC}
  };

  logic clk = 0, rst_ni = 0;
  logic cs_ni = 1, rd_ni = 1, wr_ni = 1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] data_o, out_data_o, init_cmd_o, mode_o, targ_cmd_o, sel_enable_o;
  logic data_oe_o, dma_send_o, dma_targ_rx_o, dma_init_rx_o, clr_flags_o;

  always #5 clk = ~clk;

  scsi_cpu_regs dut_i (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i(addr), .data_i(wdata),
    .data_o, .data_oe_o,
    .scsi_data_i(SCSI_V), .bus_status_i(STAT_V), .bus_and_status_i(BST_V),
    .input_data_i(IND_V),
    .out_data_o, .init_cmd_o, .mode_o, .targ_cmd_o, .sel_enable_o,
    .dma_send_o, .dma_targ_rx_o, .dma_init_rx_o, .clr_flags_o
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int c_send = 0, c_trx = 0, c_irx = 0, c_clr = 0;
  bit cnt_clr = 0;

  always @(posedge clk) begin
    if (cnt_clr) begin
      c_send <= 0; c_trx <= 0; c_irx <= 0; c_clr <= 0;
    end else begin
      c_send <= c_send + int'(dma_send_o);
      c_trx  <= c_trx  + int'(dma_targ_rx_o);
      c_irx  <= c_irx  + int'(dma_init_rx_o);
      c_clr  <= c_clr  + int'(clr_flags_o);
    end
  end

  logic [7:0] m_out = 0, m_icmd = 0, m_mode = 0, m_tcmd = 0, m_sel = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; wdata = d; cs_ni = 0; wr_ni = 0;
    wait_n(hold);
    cs_ni = 1; wr_ni = 1;
    wait_n(5);
  endtask

  task automatic cpu_read(input logic [2:0] a, input int hold, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_ni = 0; rd_ni = 0;
    @(negedge clk);
    d = data_o; oe = data_oe_o;
    wait_n(hold);
    cs_ni = 1; rd_ni = 1;
    wait_n(5);
  endtask

  task automatic check_regs(input string req);
    check(out_data_o == m_out,   {req, " out_data"}, out_data_o, m_out);
    check(init_cmd_o == m_icmd,  {req, " init_cmd"}, init_cmd_o, m_icmd);
    check(mode_o == m_mode,      {req, " mode"}, mode_o, m_mode);
    check(targ_cmd_o == m_tcmd,  {req, " targ_cmd"}, targ_cmd_o, m_tcmd);
    check(sel_enable_o == m_sel, {req, " sel_enable"}, sel_enable_o, m_sel);
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: m_out = d;
      3'd1: m_icmd = d;
      3'd2: m_mode = d;
      3'd3: m_tcmd = d;
      3'd4: m_sel = d;
      default: ; // action addresses store nothing
    endcase
  endtask

  initial begin
    logic [7:0] rd;
    logic oe;
    wait_n(3);
    // R9: reset state
    check({out_data_o, init_cmd_o, mode_o, targ_cmd_o, sel_enable_o} == '0, "R9 regs in reset", init_cmd_o, 0);
    check({dma_send_o, dma_targ_rx_o, dma_init_rx_o, clr_flags_o, data_oe_o} == '0, "R9 strobes in reset",
          {dma_send_o, dma_targ_rx_o, dma_init_rx_o, clr_flags_o}, 0);
    rst_ni = 1;
    wait_n(2);

    // table walk: R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      clear_counts();
      cpu_write(VECS[i].addr, VECS[i].wdata, 6);
      model_write(VECS[i].addr, VECS[i].wdata);
      cpu_read(VECS[i].addr, 2, rd, oe);
      check(oe === 1'b1, "R2 oe during read", oe, 1);
      check(rd == VECS[i].exp_rd, "R3/R4/R5 readback", rd, VECS[i].exp_rd);
      check(c_send == int'(VECS[i].exp_strb[0]), "R6 dma_send count", c_send, VECS[i].exp_strb[0]);
      check(c_trx  == int'(VECS[i].exp_strb[1]), "R6 dma_targ_rx count", c_trx, VECS[i].exp_strb[1]);
      check(c_irx  == int'(VECS[i].exp_strb[2]), "R6 dma_init_rx count", c_irx, VECS[i].exp_strb[2]);
      check(c_clr  == int'(VECS[i].exp_strb[3]), "R7 clr count", c_clr, VECS[i].exp_strb[3]);
      check_regs("R6 registers");
    end

    // R1: deselected write and read do nothing
    clear_counts();
    @(negedge clk); addr = 3'd1; wdata = 8'hFF; cs_ni = 1; wr_ni = 0;
    wait_n(6); wr_ni = 1;
    @(negedge clk); addr = 3'd7; rd_ni = 0;
    @(negedge clk);
    check(data_oe_o === 1'b0, "R2 oe with cs high", data_oe_o, 0);
    wait_n(6); rd_ni = 1; wait_n(5);
    check_regs("R1 deselected");
    check(c_send + c_trx + c_irx + c_clr == 0, "R1 no strobe deselected", c_send + c_trx + c_irx + c_clr, 0);

    // R2: no drive during write
    @(negedge clk); addr = 3'd2; wdata = 8'h66; cs_ni = 0; wr_ni = 0;
    @(negedge clk);
    check(data_oe_o === 1'b0, "R2 oe during write", data_oe_o, 0);
    wait_n(5); cs_ni = 1; wr_ni = 1; wait_n(5);
    model_write(3'd2, 8'h66);
    check_regs("R3 mode write");

    // R8: write latency, register updates on the third rising edge
    @(negedge clk); addr = 3'd3; wdata = 8'hD2; cs_ni = 0; wr_ni = 0;
    wait_n(2);
    check(targ_cmd_o == m_tcmd, "R8 not yet updated", targ_cmd_o, m_tcmd);
    @(negedge clk);
    check(targ_cmd_o == 8'hD2, "R8 updated after third edge", targ_cmd_o, 8'hD2);
    wait_n(3); cs_ni = 1; wr_ni = 1; wait_n(5);
    model_write(3'd3, 8'hD2);

    // R8: long strobes give a single pulse
    clear_counts();
    cpu_write(3'd5, 8'h00, 25);
    check(c_send == 1, "R8 long write one pulse", c_send, 1);
    clear_counts();
    cpu_read(3'd7, 25, rd, oe);
    check(c_clr == 1, "R8 long read one pulse", c_clr, 1);
    clear_counts();
    cpu_read(3'd2, 3, rd, oe);
    check(c_clr + c_send + c_trx + c_irx == 0, "R7 plain read no strobe", c_clr, 0);
    check(rd == 8'h66, "R3 mode readback", rd, 8'h66);

    // R9: reset mid-operation clears all
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    check({out_data_o, init_cmd_o, mode_o, targ_cmd_o, sel_enable_o} == '0, "R9 regs after reset", mode_o, 0);
    rst_ni = 1;
    wait_n(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule